// File: doc/BRIEF.md
# Crosshair Cursor Overlay with Clipping Regions

This block draws a crosshair cursor over a one-bit-per-pixel display. For each beam position it decides whether the position lies on the vertical line through the cursor column or on the horizontal line through the cursor row. The line bits feed two cursor planes. Each plane has its own enable and force control. The two plane bits are then combined with the frame-buffer data bit to give the final monochrome pixel.

Two rectangular region detectors can clip the crosshair to a window. Each detector also has its own enable and force control. The block holds a single state element: a self-test flag. The flag is set whenever either cursor plane or either region detector produces a 1. It is cleared by a command-register write, and it is read back inverted.

Register shadowing is not part of this block. The surrounding register file presents already-settled control values, and the block uses them from one pixel to the next.

Top module: `xhair_cursor`

## Requirements
- R1: A region detector is true when the beam X is at least the region's left bound and below its right bound, and the beam Y is at least its top bound and below its bottom bound. Both minimum bounds are inclusive and both maximum bounds are exclusive.
- R2: The two least significant bits of both horizontal bounds of a region are treated as zero. The vertical bounds take effect on every line.
- R3: When a region's force bit is 1, its output is 1 anywhere on the raster. Otherwise, when its enable bit is 0, its output is 0.
- R4: With `xh_wide`=0, each crosshair line is one pixel wide. With `xh_wide`=1, the column to the right of the cursor column and the row below the cursor row also count as line pixels.
- R5: With `clip_on`=0, the lines span the whole raster. With `clip_on`=1, line pixels appear only where the chosen region is true. `clip_sel`=1 chooses region 1 and `clip_sel`=0 chooses region 2.
- R6: The pixel is combined from data bit D, plane bit A and plane bit B. If A=0 and B=0 the pixel is D. If B=1 the pixel is A. If A=1 and B=0 the pixel is NOT D.
- R7: A plane's force bit makes that plane 1 everywhere. Otherwise a plane carries the crosshair line bit when its enable bit is 1, and 0 when its enable bit is 0.
- R8: While `blank` is 1, `pix_out` is 0, whatever the plane and data bits are.
- R9: The test flag is 0 after reset. A clock edge with `cmd_wr`=1 clears it. Otherwise it becomes 1 at a clock edge where plane A, plane B, region 1 or region 2 is 1, and it then holds. `test_n` is the flag inverted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| beam_x | input | XW | Current beam column |
| beam_y | input | YW | Current beam row |
| blank | input | 1 | Blanking interval, forces the pixel dark |
| fb_pix | input | 1 | Frame-buffer data bit for this position |
| cur_x | input | XW | Crosshair column |
| cur_y | input | YW | Crosshair row |
| ena_a | input | 1 | Plane A enable |
| frc_a | input | 1 | Plane A force-to-one |
| ena_b | input | 1 | Plane B enable |
| frc_b | input | 1 | Plane B force-to-one |
| xh_wide | input | 1 | Two-pixel line width |
| clip_on | input | 1 | Clip the lines to a region |
| clip_sel | input | 1 | Clip region choice, 1 = region 1, 0 = region 2 |
| rgn_en | input | 2 | Region enables, bit 0 = region 1, bit 1 = region 2 |
| rgn_frc | input | 2 | Region force bits, same bit order as rgn_en |
| r1_xmin | input | XW | Region 1 left bound, inclusive |
| r1_xmax | input | XW | Region 1 right bound, exclusive |
| r1_ymin | input | YW | Region 1 top bound, inclusive |
| r1_ymax | input | YW | Region 1 bottom bound, exclusive |
| r2_xmin | input | XW | Region 2 left bound, inclusive |
| r2_xmax | input | XW | Region 2 right bound, exclusive |
| r2_ymin | input | YW | Region 2 top bound, inclusive |
| r2_ymax | input | YW | Region 2 bottom bound, exclusive |
| cmd_wr | input | 1 | Command-register write strobe, clears the test flag |
| pix_out | output | 1 | Displayed pixel |
| test_n | output | 1 | Test flag, inverted |

## Verification
The assertions check several behaviours on every cycle:
- blanking keeps the pixel dark;
- the force bits of the planes and regions have priority;
- a disabled plane with no force stays at 0;
- when plane B is 1, the pixel follows plane A;
- the test flag is set, cleared and held as R9 describes.

Some behaviours can only be shown by the bench's scenarios, because each depends on a particular beam position relative to programmed values. These are the exact region edges and the ignored low bits of the X bounds, the one-pixel and two-pixel line geometry, and which region the clip select picks. The bench also covers the full combining table, using D together with forced plane values.

// File: rtl/xhair_pkg.sv
package xhair_pkg;

    // Enable/force pair shared by cursor planes and region detectors
    typedef struct packed {
        logic enable;
        logic force_on;
    } gate_t;

    typedef enum logic {
        CLIP_R2 = 1'b0,
        CLIP_R1 = 1'b1
    } clip_sel_e;

    localparam int unsigned NUM_REGIONS = 2;

    // Force wins; otherwise the raw hit passes only when enabled
    function automatic logic gate_apply(gate_t g, logic hit);
        return g.force_on | (g.enable & hit);
    endfunction

    // Combine data bit with plane A/B bits; blanking darkens
    function automatic logic mix_pixel(logic d, logic a, logic b, logic blank_i);
        logic p;
        if (b)
            p = a;
        else if (a)
            p = ~d;
        else
            p = d;
        return p & ~blank_i;
    endfunction

endpackage

// File: rtl/xhair_region.sv
module xhair_region
    import xhair_pkg::*;
#(
    parameter int unsigned XW = 11,
    parameter int unsigned YW = 10,
    parameter int unsigned X_GRAN_BITS = 2
) (
    input  logic [XW-1:0] x,
    input  logic [YW-1:0] y,
    input  logic [XW-1:0] xmin,
    input  logic [XW-1:0] xmax,
    input  logic [YW-1:0] ymin,
    input  logic [YW-1:0] ymax,
    input  gate_t         ctl,
    output logic          hit
);
    localparam logic [XW-1:0] GRAN_MASK = ~(XW'((1 << X_GRAN_BITS) - 1));

    logic [XW-1:0] lo_x;
    logic [XW-1:0] hi_x;
    logic          in_x;
    logic          in_y;

    always_comb begin
        lo_x = xmin & GRAN_MASK;
        hi_x = xmax & GRAN_MASK;
        in_x = (x >= lo_x) && (x < hi_x);
        in_y = (y >= ymin) && (y < ymax);
        hit  = gate_apply(ctl, in_x & in_y);
    end
endmodule

// File: rtl/xhair_lines.sv
module xhair_lines #(
    parameter int unsigned XW = 11,
    parameter int unsigned YW = 10
) (
    input  logic [XW-1:0] x,
    input  logic [YW-1:0] y,
    input  logic [XW-1:0] cx,
    input  logic [YW-1:0] cy,
    input  logic          wide,
    output logic          on_line
);
    // One extra bit so the neighbour column/row never wraps to zero
    logic [XW:0] x_e;
    logic [XW:0] cx_next;
    logic [YW:0] y_e;
    logic [YW:0] cy_next;
    logic        v_hit;
    logic        h_hit;

    always_comb begin
        x_e     = {1'b0, x};
        y_e     = {1'b0, y};
        cx_next = {1'b0, cx} + 1'b1;
        cy_next = {1'b0, cy} + 1'b1;
        v_hit   = (x == cx) | (wide & (x_e == cx_next));
        h_hit   = (y == cy) | (wide & (y_e == cy_next));
        on_line = v_hit | h_hit;
    end
endmodule

// File: rtl/xhair_testff.sv
module xhair_testff (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic set,
    output logic flag
);
    always_ff @(posedge clk) begin
        if (rst)
            flag <= 1'b0;
        else if (clr)
            flag <= 1'b0;
        else if (set)
            flag <= 1'b1;
    end
endmodule

// File: rtl/xhair_cursor.sv
module xhair_cursor
    import xhair_pkg::*;
#(
    parameter int unsigned XW = 11,
    parameter int unsigned YW = 10
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [XW-1:0] beam_x,
    input  logic [YW-1:0] beam_y,
    input  logic          blank,
    input  logic          fb_pix,
    input  logic [XW-1:0] cur_x,
    input  logic [YW-1:0] cur_y,
    input  logic          ena_a,
    input  logic          frc_a,
    input  logic          ena_b,
    input  logic          frc_b,
    input  logic          xh_wide,
    input  logic          clip_on,
    input  logic          clip_sel,
    input  logic [1:0]    rgn_en,
    input  logic [1:0]    rgn_frc,
    input  logic [XW-1:0] r1_xmin,
    input  logic [XW-1:0] r1_xmax,
    input  logic [YW-1:0] r1_ymin,
    input  logic [YW-1:0] r1_ymax,
    input  logic [XW-1:0] r2_xmin,
    input  logic [XW-1:0] r2_xmax,
    input  logic [YW-1:0] r2_ymin,
    input  logic [YW-1:0] r2_ymax,
    input  logic          cmd_wr,
    output logic          pix_out,
    output logic          test_n
);
    localparam int unsigned NR = NUM_REGIONS;

    logic [XW-1:0] bnd_xmin [NR];
    logic [XW-1:0] bnd_xmax [NR];
    logic [YW-1:0] bnd_ymin [NR];
    logic [YW-1:0] bnd_ymax [NR];
    logic [NR-1:0] rgn_hit;
    logic          line_raw;
    logic          clip_win;
    logic          line_bit;
    logic          plane_a;
    logic          plane_b;
    logic          any_hit;
    logic          test_flag;
    gate_t         gate_a;
    gate_t         gate_b;

    always_comb begin
        bnd_xmin[0] = r1_xmin;  bnd_xmax[0] = r1_xmax;
        bnd_ymin[0] = r1_ymin;  bnd_ymax[0] = r1_ymax;
        bnd_xmin[1] = r2_xmin;  bnd_xmax[1] = r2_xmax;
        bnd_ymin[1] = r2_ymin;  bnd_ymax[1] = r2_ymax;
    end

    for (genvar i = 0; i < NR; i++) begin : g_rgn
        gate_t ctl;
        assign ctl = '{enable: rgn_en[i], force_on: rgn_frc[i]};
        xhair_region #(.XW(XW), .YW(YW), .X_GRAN_BITS(2)) i_region (
            .x    (beam_x),
            .y    (beam_y),
            .xmin (bnd_xmin[i]),
            .xmax (bnd_xmax[i]),
            .ymin (bnd_ymin[i]),
            .ymax (bnd_ymax[i]),
            .ctl  (ctl),
            .hit  (rgn_hit[i])
        );
    end

    xhair_lines #(.XW(XW), .YW(YW)) i_lines (
        .x       (beam_x),
        .y       (beam_y),
        .cx      (cur_x),
        .cy      (cur_y),
        .wide    (xh_wide),
        .on_line (line_raw)
    );

    always_comb begin
        clip_win = (clip_sel_e'(clip_sel) == CLIP_R1) ? rgn_hit[0] : rgn_hit[1];
        line_bit = line_raw & (~clip_on | clip_win);
        gate_a   = '{enable: ena_a, force_on: frc_a};
        gate_b   = '{enable: ena_b, force_on: frc_b};
        plane_a  = gate_apply(gate_a, line_bit);
        plane_b  = gate_apply(gate_b, line_bit);
        any_hit  = plane_a | plane_b | (|rgn_hit);
        pix_out  = mix_pixel(fb_pix, plane_a, plane_b, blank);
        test_n   = ~test_flag;
    end

    xhair_testff i_testff (
        .clk  (clk),
        .rst  (rst),
        .clr  (cmd_wr),
        .set  (any_hit),
        .flag (test_flag)
    );
endmodule

// File: rtl/xhair_cursor_chk.sv
module xhair_cursor_chk (
    input logic       clk,
    input logic       rst,
    input logic       blank,
    input logic       ena_a,
    input logic       frc_a,
    input logic       ena_b,
    input logic       frc_b,
    input logic [1:0] rgn_frc,
    input logic [1:0] rgn_hit,
    input logic       plane_a,
    input logic       plane_b,
    input logic       any_hit,
    input logic       cmd_wr,
    input logic       pix_out,
    input logic       test_n
);
    // R8
    assert_blank_dark_R8: assert property (@(posedge clk) disable iff (rst)
        blank |-> !pix_out);

    // R7
    assert_force_a_R7: assert property (@(posedge clk) disable iff (rst)
        frc_a |-> plane_a);
    assert_force_b_R7: assert property (@(posedge clk) disable iff (rst)
        frc_b |-> plane_b);
    assert_off_a_R7: assert property (@(posedge clk) disable iff (rst)
        (!ena_a && !frc_a) |-> !plane_a);
    assert_off_b_R7: assert property (@(posedge clk) disable iff (rst)
        (!ena_b && !frc_b) |-> !plane_b);

    // R3
    assert_rgn1_force_R3: assert property (@(posedge clk) disable iff (rst)
        rgn_frc[0] |-> rgn_hit[0]);
    assert_rgn2_force_R3: assert property (@(posedge clk) disable iff (rst)
        rgn_frc[1] |-> rgn_hit[1]);

    // R6
    assert_b_selects_a_R6: assert property (@(posedge clk) disable iff (rst)
        (!blank && plane_b) |-> (pix_out == plane_a));

    // R9
    assert_wr_clears_R9: assert property (@(posedge clk) disable iff (rst)
        cmd_wr |=> test_n);
    assert_hit_sets_R9: assert property (@(posedge clk) disable iff (rst)
        (!cmd_wr && any_hit) |=> !test_n);
    assert_flag_holds_R9: assert property (@(posedge clk) disable iff (rst)
        (!cmd_wr && !test_n) |=> !test_n);
endmodule

bind xhair_cursor xhair_cursor_chk i_xhair_cursor_chk (
    .clk     (clk),
    .rst     (rst),
    .blank   (blank),
    .ena_a   (ena_a),
    .frc_a   (frc_a),
    .ena_b   (ena_b),
    .frc_b   (frc_b),
    .rgn_frc (rgn_frc),
    .rgn_hit (rgn_hit),
    .plane_a (plane_a),
    .plane_b (plane_b),
    .any_hit (any_hit),
    .cmd_wr  (cmd_wr),
    .pix_out (pix_out),
    .test_n  (test_n)
);

// File: tb/test_xhair_cursor.sv
module test_xhair_cursor;
    localparam int XW = 11;
    localparam int YW = 10;

    logic          clk = 1'b0;
    logic          rst;
    logic [XW-1:0] beam_x;
    logic [YW-1:0] beam_y;
    logic          blank;
    logic          fb_pix;
    logic [XW-1:0] cur_x;
    logic [YW-1:0] cur_y;
    logic          ena_a, frc_a, ena_b, frc_b;
    logic          xh_wide, clip_on, clip_sel;
    logic [1:0]    rgn_en, rgn_frc;
    logic [XW-1:0] r1_xmin, r1_xmax, r2_xmin, r2_xmax;
    logic [YW-1:0] r1_ymin, r1_ymax, r2_ymin, r2_ymax;
    logic          cmd_wr;
    logic          pix_out;
    logic          test_n;

    int n_chk = 0;
    int n_err = 0;

    always #5 clk = ~clk;

    xhair_cursor #(.XW(XW), .YW(YW)) i_xhair_cursor (
        .clk(clk), .rst(rst), .beam_x(beam_x), .beam_y(beam_y),
        .blank(blank), .fb_pix(fb_pix), .cur_x(cur_x), .cur_y(cur_y),
        .ena_a(ena_a), .frc_a(frc_a), .ena_b(ena_b), .frc_b(frc_b),
        .xh_wide(xh_wide), .clip_on(clip_on), .clip_sel(clip_sel),
        .rgn_en(rgn_en), .rgn_frc(rgn_frc),
        .r1_xmin(r1_xmin), .r1_xmax(r1_xmax), .r1_ymin(r1_ymin), .r1_ymax(r1_ymax),
        .r2_xmin(r2_xmin), .r2_xmax(r2_xmax), .r2_ymin(r2_ymin), .r2_ymax(r2_ymax),
        .cmd_wr(cmd_wr), .pix_out(pix_out), .test_n(test_n)
    );

    task automatic chk(string req, logic got, logic exp);
        n_chk++;
        if (got !== exp) begin
            n_err++;
            $display("FAIL %s: got %0b expected %0b", req, got, exp);
        end
    endtask

    task automatic at(int x, int y, logic exp, string req);
        beam_x = XW'(x);
        beam_y = YW'(y);
        #1;
        chk(req, pix_out, exp);
    endtask

    task automatic defaults();
        blank = 0; fb_pix = 0;
        cur_x = XW'(300); cur_y = YW'(100);
        ena_a = 1; frc_a = 0; ena_b = 1; frc_b = 0;
        xh_wide = 0; clip_on = 0; clip_sel = 1;
        rgn_en = 2'b00; rgn_frc = 2'b00;
        r1_xmin = XW'(258); r1_xmax = XW'(322);
        r1_ymin = YW'(64);  r1_ymax = YW'(128);
        r2_xmin = '0; r2_xmax = '0; r2_ymin = '0; r2_ymax = '0;
        cmd_wr = 0;
        beam_x = '0; beam_y = '0;
    endtask

    task automatic t_reset();
        rst = 1;
        defaults();
        repeat (2) @(posedge clk);
        @(negedge clk);
        chk("R9 reset test_n", test_n, 1'b1);
        rst = 0;
    endtask

    task automatic t_width();
        defaults();
        at(300, 50, 1, "R4 narrow on column");
        at(301, 50, 0, "R4 narrow right neighbour");
        at(500, 101, 0, "R4 narrow row below");
        xh_wide = 1;
        at(301, 50, 1, "R4 wide right column");
        at(299, 50, 0, "R4 wide left not drawn");
        at(500, 101, 1, "R4 wide row below");
        at(500, 99, 0, "R4 wide row above not drawn");
        at(500, 102, 0, "R4 wide two below");
    endtask

    task automatic t_clip();
        defaults();
        at(300, 20, 1, "R5 unclipped full height");
        clip_on = 1; clip_sel = 1; rgn_en = 2'b01;
        at(300, 20, 0, "R5 clipped outside region 1");
        at(300, 70, 1, "R5 clipped inside region 1");
        clip_sel = 0;
        at(300, 70, 0, "R5 select 0 uses disabled region 2");
        rgn_en = 2'b10;
        r2_xmin = XW'(0); r2_xmax = XW'(1024); r2_ymin = YW'(0); r2_ymax = YW'(40);
        at(300, 20, 1, "R5 region 2 window shows line");
        at(300, 70, 0, "R5 region 2 ignores region 1 area");
    endtask

    task automatic t_bounds();
        defaults();
        clip_on = 1; clip_sel = 1; rgn_en = 2'b01;
        at(256, 100, 1, "R2 left bound low bits ignored");
        at(255, 100, 0, "R1 left of region");
        at(319, 100, 1, "R1 last column inside");
        at(320, 100, 0, "R1 right bound exclusive");
        at(321, 100, 0, "R2 right bound low bits ignored");
        at(300, 64, 1, "R1 top bound inclusive");
        at(300, 63, 0, "R1 above top");
        at(300, 127, 1, "R1 last row inside");
        at(300, 128, 0, "R1 bottom bound exclusive");
    endtask

    task automatic t_rgn_force();
        defaults();
        clip_on = 1; clip_sel = 1;
        rgn_en = 2'b00; rgn_frc = 2'b00;
        at(300, 70, 0, "R3 disabled region clips all");
        rgn_frc = 2'b01;
        at(300, 10, 1, "R3 forced region true outside bounds");
        rgn_en = 2'b01;
        at(600, 10, 0, "R3 forced region, off line stays dark");
    endtask

    task automatic t_mix();
        defaults();
        ena_a = 0; ena_b = 0;
        fb_pix = 0; at(300, 100, 0, "R6 A0 B0 D0");
        fb_pix = 1; at(300, 100, 1, "R6 A0 B0 D1");
        frc_a = 1;
        fb_pix = 0; at(600, 10, 1, "R6 A1 B0 D0 inverted");
        fb_pix = 1; at(600, 10, 0, "R6 A1 B0 D1 inverted");
        frc_a = 0; frc_b = 1;
        fb_pix = 1; at(600, 10, 0, "R6 A0 B1 black");
        frc_a = 1;
        fb_pix = 0; at(600, 10, 1, "R6 A1 B1 white");
    endtask

    task automatic t_planes();
        defaults();
        fb_pix = 1;
        ena_a = 1; ena_b = 0;
        at(300, 10, 0, "R7 plane A only inverts on line");
        at(600, 10, 1, "R7 plane A only off line shows data");
        ena_a = 0; ena_b = 1;
        at(300, 10, 0, "R7 plane B only gives black on line");
        ena_a = 0; ena_b = 0;
        at(300, 10, 1, "R7 both disabled hide line");
        fb_pix = 0; frc_b = 1; ena_b = 0;
        ena_a = 1;
        at(300, 10, 1, "R7 force B with A on line white");
    endtask

    task automatic t_blank();
        defaults();
        frc_a = 1; frc_b = 1; fb_pix = 1;
        blank = 1;
        at(300, 100, 0, "R8 blank with forced planes");
        blank = 0;
        at(300, 100, 1, "R8 unblanked forced white");
    endtask

    task automatic t_test();
        @(negedge clk);
        defaults();
        ena_a = 0; ena_b = 0;
        beam_x = XW'(600); beam_y = YW'(10);
        cmd_wr = 1;
        @(negedge clk);
        cmd_wr = 0;
        chk("R9 write clears flag", test_n, 1'b1);
        @(negedge clk);
        chk("R9 idle keeps clear", test_n, 1'b1);
        frc_b = 1;
        @(negedge clk);
        frc_b = 0;
        chk("R9 plane B sets flag", test_n, 1'b0);
        @(negedge clk);
        chk("R9 flag holds", test_n, 1'b0);
        cmd_wr = 1;
        @(negedge clk);
        cmd_wr = 0;
        chk("R9 write clears again", test_n, 1'b1);
        rgn_en = 2'b01; beam_x = XW'(280); beam_y = YW'(80);
        @(negedge clk);
        chk("R9 region 1 sets flag", test_n, 1'b0);
    endtask

    initial begin
        #2_000_000;
        n_err++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        t_reset();
        t_width();
        t_clip();
        t_bounds();
        t_rgn_force();
        t_mix();
        t_planes();
        t_blank();
        t_test();
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule